// File: doc/BRIEF.md
# Saturating-Counter Supply Step Policy

This block decides, once per error-monitoring window, whether the supply voltage of a monitored logic domain should move up, move down, or stay. At the close of each window a strobe arrives together with the number of timing errors seen in that window and a programmable threshold. A window whose error count is strictly above the threshold raises a warning. The policy is aggressive. It keeps lowering the supply while windows are clean. It tolerates a long run of consecutive warnings before it asks for more voltage, so the domain spends more time at low supply.

Three states drive the decision. In the safe state each clean window requests one step down. The first warning moves the machine into a counting state and clears the warning counter. Every further warning increments that counter, and a clean window falls back to safe with no step. When the counter reaches its all-ones value, the block requests one step up and enters the unsafe state. The unsafe state holds the supply while warnings continue and returns to safe with a step down on the first clean window. Step requests are Mealy outputs: they depend on the state and on the current window's warning, and each lasts one cycle, the cycle in which the strobe is high.

Top module: `vp_sat_policy`

## Requirements
- R1: After reset `state_o` is 0 (safe), `warn_cnt_o` is 0, and both step outputs are low.
- R2: A warning exists only when `win_done_i` is high and `err_cnt_i` is strictly greater than `err_thr_i`. A count equal to the threshold is not a warning.
- R3: In safe (`state_o`=0), a strobe with no warning raises `step_down_o` for that cycle, and the state stays safe.
- R4: In safe, a strobe with a warning moves to counting (`state_o`=1), clears `warn_cnt_o` to 0, and raises no step.
- R5: In counting, each warning strobe increments `warn_cnt_o` by one and raises no step, as long as the new value is below the maximum 2^CNT_W-1 (31 by default).
- R6: In counting, the warning strobe that brings `warn_cnt_o` to its maximum raises `step_up_o` for that cycle and moves to unsafe (`state_o`=2).
- R7: In counting, a strobe with no warning returns to safe with no step and leaves `warn_cnt_o` unchanged.
- R8: In unsafe, a warning strobe keeps the state, holds the counter at its maximum and raises no step. A strobe with no warning raises `step_down_o` and returns to safe.
- R9: While `win_done_i` is low, no step is raised and the state and counter do not change, whatever the count and threshold inputs are.
- R10: `step_up_o` and `step_down_o` are never high in the same cycle.
- R11: Each new entry into counting clears `warn_cnt_o` to 0, whatever value it held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_done_i | input | 1 | One-cycle strobe that marks the end of a monitoring window |
| err_cnt_i | input | ERR_W | Error count of the window that just closed |
| err_thr_i | input | ERR_W | Warning threshold |
| step_up_o | output | 1 | One-cycle request to raise the supply |
| step_down_o | output | 1 | One-cycle request to lower the supply |
| state_o | output | 2 | Policy state: 0 safe, 1 counting, 2 unsafe |
| warn_cnt_o | output | CNT_W | Consecutive-warning counter |

## Verification
On every cycle the assertions check the following:
- the step outputs are mutually exclusive;
- steps appear only on strobe cycles, and nothing moves between strobes;
- a step up always lands in unsafe, and a step down always lands in safe;
- the counter is cleared whenever it is told to clear, and it never exceeds its maximum.

Only the bench scenarios can show that the full decision sequence is right: the strict comparison at equality, the exact window on which the counter reaches 31 and the step up fires, the counter value kept after a fallback to safe, and its clearing on re-entry.

// File: rtl/vp_pkg.sv
package vp_pkg;
  typedef enum logic [1:0] {
    ST_SAFE   = 2'd0,
    ST_COUNT  = 2'd1,
    ST_UNSAFE = 2'd2
  } vp_state_e;
endpackage

// File: rtl/vp_warn_cmp.sv
module vp_warn_cmp #(
  parameter int ERR_W = 16
) (
  input  logic             done_i,
  input  logic [ERR_W-1:0] err_i,
  input  logic [ERR_W-1:0] thr_i,
  output logic             warn_o
);
  // strictly above threshold, only at window end
  assign warn_o = done_i && (err_i > thr_i);
endmodule

// File: rtl/vp_sat_cnt.sv
module vp_sat_cnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_PRE = CNT_MAX - 1'b1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == CNT_PRE);

  a_r11_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  a_r5_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/vp_policy_fsm.sv
module vp_policy_fsm
  import vp_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      done_i,
  input  logic      warn_i,
  input  logic      cnt_last_i,
  output logic      cnt_clr_o,
  output logic      cnt_inc_o,
  output logic      step_up_o,
  output logic      step_down_o,
  output vp_state_e state_o
);
  vp_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    cnt_clr_o   = 1'b0;
    cnt_inc_o   = 1'b0;
    step_up_o   = 1'b0;
    step_down_o = 1'b0;
    if (done_i) begin
      unique case (state_q)
        ST_SAFE: begin
          if (warn_i) begin
            state_d   = ST_COUNT;
            cnt_clr_o = 1'b1;
          end else begin
            step_down_o = 1'b1;
          end
        end
        ST_COUNT: begin
          if (warn_i) begin
            cnt_inc_o = 1'b1;
            if (cnt_last_i) begin
              step_up_o = 1'b1;
              state_d   = ST_UNSAFE;
            end
          end else begin
            state_d = ST_SAFE;
          end
        end
        ST_UNSAFE: begin
          if (!warn_i) begin
            step_down_o = 1'b1;
            state_d     = ST_SAFE;
          end
        end
        default: state_d = ST_SAFE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_SAFE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(step_up_o && step_down_o));
  a_r9_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> (!step_up_o && !step_down_o));
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(state_q));
  a_r6_up_unsafe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_up_o |=> (state_q == ST_UNSAFE));
  a_r3_down_safe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_down_o |=> (state_q == ST_SAFE));
  a_r4_enter_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SAFE && done_i && warn_i) |=> (state_q == ST_COUNT));
endmodule

// File: rtl/vp_sat_policy.sv
module vp_sat_policy
  import vp_pkg::*;
#(
  parameter int ERR_W = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_done_i,
  input  logic [ERR_W-1:0] err_cnt_i,
  input  logic [ERR_W-1:0] err_thr_i,
  output logic             step_up_o,
  output logic             step_down_o,
  output logic [1:0]       state_o,
  output logic [CNT_W-1:0] warn_cnt_o
);
  logic      warn, cnt_clr, cnt_inc, cnt_last;
  vp_state_e state;

  vp_warn_cmp #(.ERR_W(ERR_W)) u_cmp (
    .done_i (win_done_i),
    .err_i  (err_cnt_i),
    .thr_i  (err_thr_i),
    .warn_o (warn)
  );

  vp_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .cnt_o  (warn_cnt_o),
    .last_o (cnt_last)
  );

  vp_policy_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (win_done_i),
    .warn_i      (warn),
    .cnt_last_i  (cnt_last),
    .cnt_clr_o   (cnt_clr),
    .cnt_inc_o   (cnt_inc),
    .step_up_o   (step_up_o),
    .step_down_o (step_down_o),
    .state_o     (state)
  );

  assign state_o = state;
endmodule

// File: tb/sim_vp_sat_policy.sv
module sim_vp_sat_policy;
  localparam int ERR_W = 16;
  localparam int CNT_W = 5;
  localparam int NV    = 8;

  localparam int V_ERR [NV] = '{5, 0, 6, 9, 9, 3, 100, 1};
  localparam int V_THR [NV] = '{5, 0, 5, 5, 5, 5, 2,   0};
  localparam int V_UP  [NV] = '{0, 0, 0, 0, 0, 0, 0,   0};
  localparam int V_DN  [NV] = '{1, 1, 0, 0, 0, 0, 0,   0};
  localparam int V_ST  [NV] = '{0, 0, 1, 1, 1, 0, 1,   1};
  localparam int V_CNT [NV] = '{0, 0, 0, 1, 2, 2, 0,   1};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             done = 1'b0;
  logic [ERR_W-1:0] err = '0;
  logic [ERR_W-1:0] thr = '0;
  logic             up, dn;
  logic [1:0]       st;
  logic [CNT_W-1:0] cnt;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  vp_sat_policy #(.ERR_W(ERR_W), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .win_done_i(done),
    .err_cnt_i(err), .err_thr_i(thr),
    .step_up_o(up), .step_down_o(dn), .state_o(st), .warn_cnt_o(cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one window strobe: Mealy steps checked in the strobe cycle, state after edge
  task automatic window(input int e, input int t, input int eu, input int ed,
                        input int es, input int ec, input string req);
    @(negedge clk);
    done = 1'b1; err = ERR_W'(e); thr = ERR_W'(t);
    #1;
    chk({req, " step_up"}, int'(up), eu);
    chk({req, " step_down"}, int'(dn), ed);
    @(negedge clk);
    done = 1'b0;
    chk({req, " state"}, int'(st), es);
    chk({req, " count"}, int'(cnt), ec);
  endtask

  initial begin
    #2000000;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 state", int'(st), 0);
    chk("R1 count", int'(cnt), 0);
    chk("R1 steps", int'(up | dn), 0);
    rst_n = 1'b1;

    // table: R2 equality, R3, R4, R5, R7, R11 re-entry clear
    for (int i = 0; i < NV; i++)
      window(V_ERR[i], V_THR[i], V_UP[i], V_DN[i], V_ST[i], V_CNT[i], "R2/R3/R4/R5/R7/R11 vec");

    // R5 run of warnings up to one below max
    for (int k = 2; k < 31; k++) window(7, 1, 0, 0, 1, k, "R5 run");
    // R6 saturation raises step up
    window(7, 1, 1, 0, 2, 31, "R6 saturate");
    // R8 unsafe with warning holds
    window(50, 4, 0, 0, 2, 31, "R8 hold");
    window(50, 4, 0, 0, 2, 31, "R8 hold2");
    // R8 unsafe clean window steps down
    window(4, 4, 0, 1, 0, 31, "R8 release");
    // R3 repeated step down in safe
    window(0, 9, 0, 1, 0, 31, "R3 repeat");
    // R11 re-entry clears a max count
    window(10, 9, 0, 0, 1, 0, "R11 reentry");

    // R9 no strobe: over-threshold data ignored
    err = 16'hffff; thr = '0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R9 no step", int'(up | dn), 0);
      chk("R9 state", int'(st), 1);
      chk("R9 count", int'(cnt), 0);
    end
    window(1, 0, 0, 0, 1, 1, "R9 resume");

    // R1 reset mid run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 rerst state", int'(st), 0);
    chk("R1 rerst count", int'(cnt), 0);
    rst_n = 1'b1;
    window(2, 3, 0, 1, 0, 0, "R1/R3 after reset");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule